// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a behavioural synchronous SRAM with a four-beat burst address generator. It is meant to sit behind a processor or cache controller that issues burst transfers. A transfer opens when either of two address strobes is seen on a rising clock edge. One strobe belongs to the processor and the other to the cache controller. On that edge the block captures the word address and the three chip selects. The two low address bits then seed a 2-bit beat counter. Each cycle with the advance input high steps the counter by one. The counter is mapped to a word address in either wrap-around linear order or XOR (interleaved) order, and a static order pin chooses between them.

Reads are flow-through. The word at the registered address drives the output in the cycle that follows the capturing edge, so a burst read delivers its words in a 2-1-1-1 pattern. Writes are registered together with their data. Each write is committed one edge later to the address that is current in that cycle. A write can cover the whole word or a chosen set of 9-bit lanes. The output-drive enable and the sleep input act without the clock. Sleep also stops writes from being committed and leaves the stored contents intact.

Top module: `fbs_sram`

## Requirements
- R1: While reset is high, and after it is released until a selecting strobe is captured, the block is deselected: `q_drive` is 0 and `q` is all zeros.
- R2: With `order_sel` = 0, the two low bits of the word address step through start, start+1, start+2, start+3 modulo 4, one step per advance cycle. The upper address bits stay those that were captured.
- R3: With `order_sel` = 1, the two low address bits step through start XOR 0, XOR 1, XOR 2, XOR 3.
- R4: The edge that captures a strobe sets the address to `addr` and the beat to 0. The captured word appears on `q` in the cycle right after that edge, and every later beat appears one cycle after the edge at which `adv` was high (a 2-1-1-1 pattern).
- R5: When no strobe is accepted and `adv` is low, the burst address is held.
- R6: A processor strobe with `cs_n` high is ignored and the current selection and address are kept. With `cs_n` low, a processor strobe opens a new burst.
- R7: In a cycle where only the processor strobe is accepted, the write inputs are ignored. When both strobes are high, the controller strobe takes priority and a write in that cycle is honoured.
- R8: A captured cycle selects the block only if `cs_n` = 0, `cs_hi` = 1 and `cs2_n` = 0. When the block is deselected, `q_drive` is 0 and no write is committed.
- R9: With `all_wr_n` = 0, every lane is written. Otherwise, with `bytewr_n` = 0, only lane i with `lane_wr_n[i]` = 0 is written. Otherwise nothing is written. Lane i is data bits 9i+8 down to 9i.
- R10: Write data and write enables are sampled at the edge that ends the cycle in which they are presented. They are committed at the next edge to the address held between the two edges, so the old word is still read in the cycle between.
- R11: `out_en_n` high forces `q_drive` to 0 at once, without waiting for a clock edge.
- R12: `sleep` high forces `q_drive` to 0 at once and blocks any commit while it is high. The stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, captured on an accepted strobe |
| cpu_strobe | input | 1 | Processor address strobe, active high |
| ctl_strobe | input | 1 | Controller address strobe, active high, has priority |
| adv | input | 1 | Step the burst to the next beat |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Expansion chip select, active high |
| cs2_n | input | 1 | Expansion chip select, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| all_wr_n | input | 1 | Write all lanes, active low |
| bytewr_n | input | 1 | Enable per-lane writes, active low |
| lane_wr_n | input | DW/9 | Per-lane write selects, active low |
| din | input | DW | Write data |
| out_en_n | input | 1 | Output drive enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous |
| q | output | DW | Read data, zero when not driven |
| q_drive | output | 1 | High when `q` would drive the bus (low means high impedance) |

## Verification
A wrong beat counter or a wrong order mapping puts the neighbouring word of the same four-word group on `q`. This shows one cycle after the faulty advance, so every burst read is checked beat by beat against a pre-filled pattern in which every word is distinct. A wrong selection or strobe decision shows as a change on `q_drive` or `q` in the first cycle after the edge. A misrouted or mistimed write can hide until the word is read back. For that reason each write is read twice: once in the cycle between sampling and commit, where the old word is expected, and once after the commit.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int LANE_BITS = 9;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [1:0] start;
        logic [1:0] beat;
    } burst_state_t;

    function automatic logic [1:0] beat_offset(input burst_state_t st,
                                               input burst_order_e order);
        logic [1:0] res;
        if (order == ORDER_INTERLEAVED) res = st.start ^ st.beat;
        else                            res = st.start + st.beat;
        return res;
    endfunction

endpackage

// File: rtl/fbs_burst_ctr.sv
module fbs_burst_ctr
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       step,
    input  logic [1:0] start_in,
    input  logic       order_sel,
    output logic [1:0] beat,
    output logic [1:0] lo_addr
);
    burst_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q.start <= start_in;
            st_q.beat  <= 2'd0;
        end else if (step) begin
            st_q.beat  <= st_q.beat + 2'd1;
        end
    end

    assign beat    = st_q.beat;
    assign lo_addr = beat_offset(st_q, burst_order_e'(order_sel));
endmodule

// File: rtl/fbs_lane_mask.sv
module fbs_lane_mask #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             bytewr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_en
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = ~all_wr_n | (~bytewr_n & ~lane_wr_n[i]);
    end
endmodule

// File: rtl/fbs_mem_array.sv
module fbs_mem_array
    import fbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] lane_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_BITS-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[i]) begin
                cells[addr] <= wdata[i*LANE_BITS +: LANE_BITS];
            end
        end

        assign rdata[i*LANE_BITS +: LANE_BITS] = cells[addr];
    end
endmodule

// File: rtl/fbs_sram.sv
module fbs_sram
    import fbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 36,
    localparam int LANES = DW / LANE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             cpu_strobe,
    input  logic             ctl_strobe,
    input  logic             adv,
    input  logic             cs_n,
    input  logic             cs_hi,
    input  logic             cs2_n,
    input  logic             order_sel,
    input  logic             all_wr_n,
    input  logic             bytewr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [DW-1:0]    din,
    input  logic             out_en_n,
    input  logic             sleep,
    output logic [DW-1:0]    q,
    output logic             q_drive
);
    logic             accept;
    logic             sel_next;
    logic [LANES-1:0] lane_en_now;
    logic             wr_now;

    logic             sel_q;
    logic [AW-3:0]    hi_q;
    logic             pend_q;
    logic [LANES-1:0] lanes_q;
    logic [DW-1:0]    din_q;

    logic [1:0]       beat;
    logic [1:0]       lo_addr;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    rdata;

    // Controller strobe always counts; the processor strobe needs the primary select.
    assign accept   = ctl_strobe | (cpu_strobe & ~cs_n);
    assign sel_next = ~cs_n & cs_hi & ~cs2_n;
    assign wr_now   = |lane_en_now;

    fbs_lane_mask #(.LANES(LANES)) u_mask (
        .all_wr_n  (all_wr_n),
        .bytewr_n  (bytewr_n),
        .lane_wr_n (lane_wr_n),
        .lane_en   (lane_en_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            hi_q    <= '0;
            pend_q  <= 1'b0;
            lanes_q <= '0;
            din_q   <= '0;
        end else begin
            if (accept) begin
                sel_q  <= sel_next;
                hi_q   <= addr[AW-1:2];
                // A start taken by the processor strobe alone is always a read.
                pend_q <= ctl_strobe & sel_next & wr_now;
            end else begin
                pend_q <= sel_q & wr_now;
            end
            lanes_q <= lane_en_now;
            din_q   <= din;
        end
    end

    fbs_burst_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (adv & sel_q),
        .start_in  (addr[1:0]),
        .order_sel (order_sel),
        .beat      (beat),
        .lo_addr   (lo_addr)
    );

    assign cur_addr = {hi_q, lo_addr};

    fbs_mem_array #(.AW(AW), .LANES(LANES)) u_mem (
        .clk     (clk),
        .we      (pend_q & ~sleep),
        .lane_en (lanes_q),
        .addr    (cur_addr),
        .wdata   (din_q),
        .rdata   (rdata)
    );

    assign q_drive = sel_q & ~out_en_n & ~sleep;
    assign q       = q_drive ? rdata : '0;
endmodule

// File: rtl/fbs_sram_chk.sv
module fbs_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_strobe,
    input logic          ctl_strobe,
    input logic          adv,
    input logic          cs_n,
    input logic          cs_hi,
    input logic          cs2_n,
    input logic [AW-1:0] addr,
    input logic          out_en_n,
    input logic          sleep,
    input logic          q_drive,
    input logic [AW-1:0] cur_addr,
    input logic [1:0]    beat,
    input logic          sel_q
);
    // R1
    reset_deselect_chk: assert property (@(posedge clk) rst |=> !q_drive);

    // R4
    strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe || (cpu_strobe && !cs_n)) |=> (cur_addr == $past(addr)) && (beat == 2'd0));

    // R5
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_strobe && !(cpu_strobe && !cs_n) && !adv) |=> $stable(beat));

    // R6
    cpu_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && cs_n && !ctl_strobe) |=> $stable(sel_q));

    // R8
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_strobe || (cpu_strobe && !cs_n)) && !(!cs_n && cs_hi && !cs2_n)) |=> !q_drive);

    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (rst) out_en_n |-> !q_drive);

    // R12
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst) sleep |-> !q_drive);
endmodule

bind fbs_sram fbs_sram_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_strobe (cpu_strobe),
    .ctl_strobe (ctl_strobe),
    .adv        (adv),
    .cs_n       (cs_n),
    .cs_hi      (cs_hi),
    .cs2_n      (cs2_n),
    .addr       (addr),
    .out_en_n   (out_en_n),
    .sleep      (sleep),
    .q_drive    (q_drive),
    .cur_addr   (cur_addr),
    .beat       (beat),
    .sel_q      (sel_q)
);

// File: tb/fbs_sram_tb.sv
`timescale 1ns/1ps
module fbs_sram_tb;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int LANES = 4;
    localparam int DEPTH = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic             cpu_strobe = 1'b0, ctl_strobe = 1'b0, adv = 1'b0;
    logic             cs_n = 1'b0, cs_hi = 1'b1, cs2_n = 1'b0;
    logic             order_sel = 1'b0;
    logic             all_wr_n = 1'b1, bytewr_n = 1'b1;
    logic [LANES-1:0] lane_wr_n = '1;
    logic [DW-1:0]    din = '0;
    logic             out_en_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0]    q;
    logic             q_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    fbs_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .cpu_strobe(cpu_strobe),
        .ctl_strobe(ctl_strobe), .adv(adv), .cs_n(cs_n), .cs_hi(cs_hi),
        .cs2_n(cs2_n), .order_sel(order_sel), .all_wr_n(all_wr_n),
        .bytewr_n(bytewr_n), .lane_wr_n(lane_wr_n), .din(din),
        .out_en_n(out_en_n), .sleep(sleep), .q(q), .q_drive(q_drive)
    );

    // {order, start address, expected low bits of beats 0..3}
    localparam logic [14:0] VEC [8] = '{
        {1'b0, 6'd8,  2'd0, 2'd1, 2'd2, 2'd3},
        {1'b0, 6'd13, 2'd1, 2'd2, 2'd3, 2'd0},
        {1'b0, 6'd22, 2'd2, 2'd3, 2'd0, 2'd1},
        {1'b0, 6'd63, 2'd3, 2'd0, 2'd1, 2'd2},
        {1'b1, 6'd4,  2'd0, 2'd1, 2'd2, 2'd3},
        {1'b1, 6'd17, 2'd1, 2'd0, 2'd3, 2'd2},
        {1'b1, 6'd42, 2'd2, 2'd3, 2'd0, 2'd1},
        {1'b1, 6'd31, 2'd3, 2'd2, 2'd1, 2'd0}
    };

    function automatic logic [DW-1:0] pat(input int a);
        logic [5:0] x;
        x = a[5:0];
        return {x, ~x, x ^ 6'h2A, ~x ^ 6'h15, x + 6'd7, x ^ 6'h3F};
    endfunction

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] en);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++) if (en[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        cpu_strobe = 1'b0; ctl_strobe = 1'b0; adv = 1'b0;
        all_wr_n = 1'b1; bytewr_n = 1'b1; lane_wr_n = '1;
        cs_n = 1'b0; cs_hi = 1'b1; cs2_n = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_start(input int a);
        quiet();
        addr = a[AW-1:0];
        ctl_strobe = 1'b1;
        tick();
        ctl_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [14:0] v;
        logic [AW-1:0] ea;
        logic [DW-1:0] exp_w;

        // R1: reset state
        repeat (3) tick();
        chk("R1 q_drive in reset", q_drive, 0);
        rst = 1'b0;
        tick();
        chk("R1 q_drive after reset", q_drive, 0);
        chk("R1 q after reset", q, 0);

        // Fill memory with distinct words, back-to-back controller writes.
        for (int a = 0; a < DEPTH; a++) begin
            addr = a[AW-1:0]; ctl_strobe = 1'b1; all_wr_n = 1'b0; din = pat(a);
            model[a] = pat(a);
            tick();
        end
        quiet();
        tick();

        // R2 R3 R4: burst order table
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            order_sel = v[14];
            read_start(int'(v[13:8]));
            for (int b = 0; b < 4; b++) begin
                ea = {v[13:10], v[7-2*b -: 2]};
                chk(v[14] ? "R3 interleaved beat (R4)" : "R2 linear beat (R4)", q, model[ea]);
                chk("R4 q_drive in burst", q_drive, 1);
                adv = (b < 3);
                tick();
            end
            adv = 1'b0;
        end
        order_sel = 1'b0;

        // R5: hold without advance
        read_start(37);
        chk("R5 first beat", q, model[37]);
        tick();
        chk("R5 held one", q, model[37]);
        tick();
        chk("R5 held two", q, model[37]);
        adv = 1'b1;
        tick();
        adv = 1'b0;
        chk("R5 step after hold", q, model[38]);

        // R6: processor strobe without primary select is ignored
        cpu_strobe = 1'b1; cs_n = 1'b1; addr = 6'd10;
        tick();
        quiet();
        chk("R6 ignored strobe keeps word", q, model[38]);
        chk("R6 ignored strobe keeps drive", q_drive, 1);
        cpu_strobe = 1'b1; addr = 6'd10;
        tick();
        quiet();
        chk("R6 accepted processor strobe", q, model[10]);

        // R7: processor-only start ignores writes
        cpu_strobe = 1'b1; addr = 6'd11; all_wr_n = 1'b0; din = '0;
        tick();
        quiet();
        chk("R7 processor write cycle reads", q, model[11]);
        tick();
        chk("R7 processor write not committed", q, model[11]);
        // R7: both strobes, controller wins and writes
        ctl_strobe = 1'b1; cpu_strobe = 1'b1; addr = 6'd12; all_wr_n = 1'b0;
        din = 36'hA_BCDE_F012; model[12] = 36'hA_BCDE_F012;
        tick();
        quiet();
        tick();
        chk("R7 controller priority write", q, model[12]);

        // R9 R10: lane writes
        ctl_strobe = 1'b1; addr = 6'd50; bytewr_n = 1'b0; lane_wr_n = 4'b1010; din = '1;
        tick();
        quiet();
        chk("R10 old word before commit", q, model[50]);
        tick();
        model[50] = lane_merge(model[50], '1, 4'b0101);
        chk("R9 lanes 0 and 2 written", q, model[50]);
        ctl_strobe = 1'b1; addr = 6'd50; lane_wr_n = 4'b0000; din = '0;
        tick();
        quiet();
        tick();
        chk("R9 no write without enables", q, model[50]);
        ctl_strobe = 1'b1; addr = 6'd51; all_wr_n = 1'b0; bytewr_n = 1'b0;
        lane_wr_n = 4'b1111; din = 36'h1_2345_6789;
        tick();
        quiet();
        tick();
        model[51] = 36'h1_2345_6789;
        chk("R9 global write all lanes", q, model[51]);

        // R10: interleaved burst write from start 2 (22, 23, 20, 21)
        order_sel = 1'b1;
        ctl_strobe = 1'b1; addr = 6'd22; all_wr_n = 1'b0; din = 36'h0_0000_0AAA;
        tick();
        ctl_strobe = 1'b0; adv = 1'b1; din = 36'h0_0000_0BBB;
        tick();
        din = 36'h0_0000_0CCC;
        tick();
        din = 36'h0_0000_0DDD;
        tick();
        quiet();
        tick();
        model[22] = 36'h0_0000_0AAA; model[23] = 36'h0_0000_0BBB;
        model[20] = 36'h0_0000_0CCC; model[21] = 36'h0_0000_0DDD;
        read_start(22);
        for (int b = 0; b < 4; b++) begin
            ea = {4'd5, 2'd2 ^ 2'(b)};
            chk("R10 burst write beat", q, model[ea]);
            adv = 1'b1;
            tick();
        end
        quiet();
        order_sel = 1'b0;

        // R8: chip selects
        ctl_strobe = 1'b1; addr = 6'd40; cs_hi = 1'b0;
        tick();
        quiet();
        chk("R8 deselected by cs_hi", q_drive, 0);
        ctl_strobe = 1'b1; addr = 6'd40; cs2_n = 1'b1; all_wr_n = 1'b0; din = '0;
        tick();
        quiet();
        chk("R8 deselected by cs2_n", q_drive, 0);
        tick();
        read_start(40);
        chk("R8 no write while deselected", q, model[40]);

        // R11: asynchronous output enable
        out_en_n = 1'b1;
        #1;
        chk("R11 drive off", q_drive, 0);
        chk("R11 q zero", q, 0);
        out_en_n = 1'b0;
        #1;
        chk("R11 drive back", q, model[40]);

        // R12: sleep
        sleep = 1'b1;
        #1;
        chk("R12 drive off in sleep", q_drive, 0);
        ctl_strobe = 1'b1; addr = 6'd41; all_wr_n = 1'b0; din = '0;
        tick();
        quiet();
        tick();
        tick();
        sleep = 1'b0;
        #1;
        chk("R12 contents kept, write blocked", q, model[41]);
        chk("R12 drive after wake", q_drive, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule